// File: doc/BRIEF.md
# IO Coherency Snoop Bridge

This bridge sits between an IO master that keeps no cache (a DMA engine, for example) and a shared memory. It keeps that master's traffic coherent with a processor cluster whose cache is write-back. Each IO request carries one full cache line, a line address and per-byte write enables. The bridge takes one request at a time.

When an address falls in a coherent region, the bridge first sends a snoop to the cluster. A write sends a write-back-invalidate snoop. If the cluster answers with a dirty victim line, the enabled IO bytes are laid over that victim and the combined line goes to memory as a single full-line write. A read sends a read snoop. If the answer is dirty, the cluster's copy is returned straight away and memory is not accessed; otherwise the line is read from memory.

There are two coherent regions: a large external window and a smaller on-chip scratch region. Addresses outside both skip the snoop and go directly to memory.

Top module: `coh_snoop_bridge`

## Requirements
- R1: `ioReady` is high only when no request is in progress. After a request is accepted (`ioValid` and `ioReady` high at a rising edge), `ioReady` stays low until the cycle after the `ioRspValid` pulse.
- R2: For a request in a coherent region, no memory request is issued until the snoop response has arrived.
- R3: An address is coherent if it lies in 0x08_0000_0000..0x09_FFFF_FFFF or in the scratch range SCR_BASE..SCR_LAST (default 0x00_0C00_0000..0x00_0C5F_FFFF). Coherent requests issue exactly one snoop. All other requests issue none.
- R4: A write whose snoop returns dirty produces one memory write with `memReqBe` all ones. Byte b of that write is IO byte b where `ioBe[b]` is 1, and victim byte b where it is 0. Byte b occupies data bits [8b+7:8b].
- R5: A write that is non-coherent, or whose snoop is not dirty, produces one memory write carrying the IO data with `memReqBe` equal to `ioBe`.
- R6: A coherent read whose snoop returns dirty returns the snoop data on `ioRdata` and issues no memory request.
- R7: Any other read issues one memory read and returns the memory response data on `ioRdata`.
- R8: Each request ends with exactly one single-cycle `ioRspValid` pulse. For reads, `ioRdata` is valid during that pulse.
- R9: The snoop carries `snpReqInv`=1 for writes and 0 for reads. Snoop and memory addresses are the request address with its low log2(LINE_BYTES) bits cleared.
- R10: While reset is asserted and in the first cycle after it, `ioReady` is 1 and `snpReqValid`, `memReqValid` and `ioRspValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioValid | input | 1 | IO request valid |
| ioReady | output | 1 | Bridge idle, request accepted |
| ioWrite | input | 1 | 1 = write, 0 = read |
| ioAddr | input | 40 | Byte address |
| ioWdata | input | 512 | Write line |
| ioBe | input | 64 | Per-byte write enables |
| ioRspValid | output | 1 | Completion pulse |
| ioRdata | output | 512 | Read line |
| snpReqValid | output | 1 | Snoop request, held until response |
| snpReqInv | output | 1 | 1 = write-back-invalidate, 0 = read snoop |
| snpReqAddr | output | 40 | Line address of snoop |
| snpRspValid | input | 1 | Snoop response strobe |
| snpRspDirty | input | 1 | Response carries a dirty line |
| snpRspData | input | 512 | Dirty line data |
| memReqValid | output | 1 | Memory request, held until response |
| memReqWrite | output | 1 | 1 = write, 0 = read |
| memReqAddr | output | 40 | Line address |
| memReqData | output | 512 | Write line |
| memReqBe | output | 64 | Byte enables of the write |
| memRspValid | input | 1 | Memory response strobe |
| memRspData | input | 512 | Read line |

## Verification
A request is accepted at a rising edge, and `snpReqValid` or `memReqValid` rises at the next edge. A response strobe sampled at an edge moves the bridge on by one stage: the memory request, or the `ioRspValid` pulse after a dirty read, appears at the following edge. `ioReady` returns one edge after the pulse. The bench drives inputs and samples outputs only on falling edges. It waits for each stage's valid with a bounded poll before comparing the outputs, and checks that `ioReady` is low one cycle after acceptance and high one cycle after the pulse. Snoop and memory requests are counted on their rising edges and compared per request. A reference memory, updated by bench functions, is compared line by line at the end.

// File: rtl/coh_bridge_pkg.sv
package coh_bridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SNOOP = 2'd1,
    ST_MEM   = 2'd2,
    ST_RESP  = 2'd3
  } bridgeState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch a new IO request
    logic takeSnoop;  // latch snoop response
    logic takeMem;    // latch memory response
  } ctlStrobes_t;
endpackage

// File: rtl/coh_bridge_datapath.sv
module coh_bridge_datapath
  import coh_bridge_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int LINE_BYTES = 64,
  parameter logic [ADDR_W-1:0] WIN_BASE = 40'h08_0000_0000,
  parameter logic [ADDR_W-1:0] WIN_LAST = 40'h09_FFFF_FFFF,
  parameter logic [ADDR_W-1:0] SCR_BASE = 40'h00_0C00_0000,
  parameter logic [ADDR_W-1:0] SCR_LAST = 40'h00_0C5F_FFFF
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobes_t             ctl,
  input  logic                    ioWrite,
  input  logic [ADDR_W-1:0]       ioAddr,
  input  logic [LINE_BYTES*8-1:0] ioWdata,
  input  logic [LINE_BYTES-1:0]   ioBe,
  input  logic                    snpRspDirty,
  input  logic [LINE_BYTES*8-1:0] snpRspData,
  input  logic [LINE_BYTES*8-1:0] memRspData,
  output logic                    ioCoh,
  output logic                    reqWrite,
  output logic                    reqCoh,
  output logic [ADDR_W-1:0]       lineAddr,
  output logic [LINE_BYTES*8-1:0] memReqData,
  output logic [LINE_BYTES-1:0]   memReqBe,
  output logic [LINE_BYTES*8-1:0] ioRdata
);
  localparam int DATA_W = LINE_BYTES * 8;
  localparam int OFS_W  = $clog2(LINE_BYTES);

  logic [ADDR_W-1:0]     addrQ;
  logic [DATA_W-1:0]     wdataQ, victimQ, rdataQ;
  logic [LINE_BYTES-1:0] beQ;
  logic                  writeQ, cohQ, dirtyQ;

  assign ioCoh = ((ioAddr >= WIN_BASE) && (ioAddr <= WIN_LAST)) ||
                 ((ioAddr >= SCR_BASE) && (ioAddr <= SCR_LAST));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      beQ     <= '0;
      writeQ  <= 1'b0;
      cohQ    <= 1'b0;
      dirtyQ  <= 1'b0;
      victimQ <= '0;
      rdataQ  <= '0;
    end else begin
      if (ctl.capture) begin
        addrQ  <= {ioAddr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        wdataQ <= ioWdata;
        beQ    <= ioBe;
        writeQ <= ioWrite;
        cohQ   <= ioCoh;
        dirtyQ <= 1'b0;
      end
      if (ctl.takeSnoop) begin
        dirtyQ  <= snpRspDirty;
        victimQ <= snpRspData;
        if (!writeQ && snpRspDirty) rdataQ <= snpRspData;
      end
      if (ctl.takeMem && !writeQ) rdataQ <= memRspData;
    end
  end

  // Byte-wise merge of IO data over the dirty victim
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_merge
    assign memReqData[b*8 +: 8] = (beQ[b] || !dirtyQ) ? wdataQ[b*8 +: 8]
                                                      : victimQ[b*8 +: 8];
  end

  assign memReqBe = dirtyQ ? {LINE_BYTES{1'b1}} : beQ;
  assign reqWrite = writeQ;
  assign reqCoh   = cohQ;
  assign lineAddr = addrQ;
  assign ioRdata  = rdataQ;

  // R4: a dirty snoop answer to a write forces a full-line memory write
  a_r4_full_line_after_dirty: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.takeSnoop && snpRspDirty && writeQ) |=> (memReqBe == {LINE_BYTES{1'b1}}));

  // R9: line addresses carry no byte offset
  a_r9_line_aligned: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeSnoop |-> (lineAddr[OFS_W-1:0] == '0));
endmodule

// File: rtl/coh_bridge_ctrl.sv
module coh_bridge_ctrl
  import coh_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ioValid,
  input  logic        ioCoh,
  input  logic        reqWrite,
  input  logic        reqCoh,
  input  logic        snpRspValid,
  input  logic        snpRspDirty,
  input  logic        memRspValid,
  output logic        ioReady,
  output logic        ioRspValid,
  output logic        snpReqValid,
  output logic        snpReqInv,
  output logic        memReqValid,
  output logic        memReqWrite,
  output ctlStrobes_t ctl
);
  bridgeState_t state, stateNext;
  logic         snoopSeen;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: if (ioValid) begin
        ctl.capture = 1'b1;
        stateNext   = ioCoh ? ST_SNOOP : ST_MEM;
      end
      ST_SNOOP: if (snpRspValid) begin
        ctl.takeSnoop = 1'b1;
        stateNext     = (!reqWrite && snpRspDirty) ? ST_RESP : ST_MEM;
      end
      ST_MEM: if (memRspValid) begin
        ctl.takeMem = 1'b1;
        stateNext   = ST_RESP;
      end
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      snoopSeen <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctl.capture)        snoopSeen <= 1'b0;
      else if (ctl.takeSnoop) snoopSeen <= 1'b1;
    end
  end

  assign ioReady     = (state == ST_IDLE);
  assign ioRspValid  = (state == ST_RESP);
  assign snpReqValid = (state == ST_SNOOP);
  assign snpReqInv   = reqWrite;
  assign memReqValid = (state == ST_MEM);
  assign memReqWrite = reqWrite;

  // R1: busy right after acceptance
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (ioValid && ioReady) |=> !ioReady);

  // R2: coherent memory access only after the snoop answered
  a_r2_snoop_before_mem: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && reqCoh) |-> snoopSeen);

  // R3: non-coherent requests never snoop
  a_r3_bypass_no_snoop: assert property (@(posedge clk) disable iff (!rstN)
    snpReqValid |-> reqCoh);

  // R6: dirty read is served without memory
  a_r6_dirty_read_no_mem: assert property (@(posedge clk) disable iff (!rstN)
    (snpReqValid && snpRspValid && snpRspDirty && !reqWrite) |=> (!memReqValid && ioRspValid));

  // R8: completion is a single-cycle pulse
  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ioRspValid |=> (!ioRspValid && ioReady));
endmodule

// File: rtl/coh_snoop_bridge.sv
module coh_snoop_bridge
  import coh_bridge_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int LINE_BYTES = 64,
  parameter logic [ADDR_W-1:0] WIN_BASE = 40'h08_0000_0000,
  parameter logic [ADDR_W-1:0] WIN_LAST = 40'h09_FFFF_FFFF,
  parameter logic [ADDR_W-1:0] SCR_BASE = 40'h00_0C00_0000,
  parameter logic [ADDR_W-1:0] SCR_LAST = 40'h00_0C5F_FFFF
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ioValid,
  output logic                    ioReady,
  input  logic                    ioWrite,
  input  logic [ADDR_W-1:0]       ioAddr,
  input  logic [LINE_BYTES*8-1:0] ioWdata,
  input  logic [LINE_BYTES-1:0]   ioBe,
  output logic                    ioRspValid,
  output logic [LINE_BYTES*8-1:0] ioRdata,
  output logic                    snpReqValid,
  output logic                    snpReqInv,
  output logic [ADDR_W-1:0]       snpReqAddr,
  input  logic                    snpRspValid,
  input  logic                    snpRspDirty,
  input  logic [LINE_BYTES*8-1:0] snpRspData,
  output logic                    memReqValid,
  output logic                    memReqWrite,
  output logic [ADDR_W-1:0]       memReqAddr,
  output logic [LINE_BYTES*8-1:0] memReqData,
  output logic [LINE_BYTES-1:0]   memReqBe,
  input  logic                    memRspValid,
  input  logic [LINE_BYTES*8-1:0] memRspData
);
  ctlStrobes_t       ctl;
  logic              ioCoh, reqWrite, reqCoh;
  logic [ADDR_W-1:0] lineAddr;

  coh_bridge_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ioValid(ioValid), .ioCoh(ioCoh),
    .reqWrite(reqWrite), .reqCoh(reqCoh),
    .snpRspValid(snpRspValid), .snpRspDirty(snpRspDirty), .memRspValid(memRspValid),
    .ioReady(ioReady), .ioRspValid(ioRspValid),
    .snpReqValid(snpReqValid), .snpReqInv(snpReqInv),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .ctl(ctl)
  );

  coh_bridge_datapath #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
    .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST),
    .SCR_BASE(SCR_BASE), .SCR_LAST(SCR_LAST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .ioWrite(ioWrite), .ioAddr(ioAddr), .ioWdata(ioWdata), .ioBe(ioBe),
    .snpRspDirty(snpRspDirty), .snpRspData(snpRspData), .memRspData(memRspData),
    .ioCoh(ioCoh), .reqWrite(reqWrite), .reqCoh(reqCoh), .lineAddr(lineAddr),
    .memReqData(memReqData), .memReqBe(memReqBe), .ioRdata(ioRdata)
  );

  assign snpReqAddr = lineAddr;
  assign memReqAddr = lineAddr;

  // R10: quiet outputs right after reset
  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(!rstN) |-> (ioReady && !snpReqValid && !memReqValid && !ioRspValid));
endmodule

// File: tb/coh_snoop_bridge_tb_top.sv
module coh_snoop_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NLINES = 8;
  localparam int WAIT_MAX = 40;
  typedef logic [511:0] line_t;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        ioValid = 1'b0, ioWrite = 1'b0;
  logic [39:0] ioAddr = '0;
  line_t       ioWdata = '0;
  logic [63:0] ioBe = '0;
  logic        snpRspValid = 1'b0, snpRspDirty = 1'b0;
  line_t       snpRspData = '0, memRspData = '0;
  logic        memRspValid = 1'b0;
  logic        ioReady, ioRspValid, snpReqValid, snpReqInv, memReqValid, memReqWrite;
  logic [39:0] snpReqAddr, memReqAddr;
  line_t       ioRdata, memReqData;
  logic [63:0] memReqBe;

  coh_snoop_bridge dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFails = 0;
  int snpCount = 0, memCount = 0, cycles = 0;
  logic prevSnp = 1'b0, prevMem = 1'b0;
  logic [39:0] lineAddrs [NLINES];
  line_t dutMem [NLINES];
  line_t refMem [NLINES];

  always @(negedge clk) begin
    cycles++;
    if (snpReqValid && !prevSnp) snpCount++;
    if (memReqValid && !prevMem) memCount++;
    prevSnp = snpReqValid;
    prevMem = memReqValid;
  end

  task automatic check(bit ok, string req, string what, line_t act, line_t exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic line_t randLine();
    line_t r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom();
    return r;
  endfunction

  // R3 region rule, written from the requirement
  function automatic bit cohRef(logic [39:0] a);
    return (a >= 40'h08_0000_0000 && a <= 40'h09_FFFF_FFFF) ||
           (a >= 40'h00_0C00_0000 && a <= 40'h00_0C5F_FFFF);
  endfunction

  function automatic line_t overlay(line_t base, line_t nw, logic [63:0] be);
    line_t r = base;
    for (int b = 0; b < 64; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  function automatic line_t beMask(logic [63:0] be);
    line_t m = '0;
    for (int b = 0; b < 64; b++) if (be[b]) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic int idxOf(logic [39:0] a);
    for (int i = 0; i < NLINES; i++) if (lineAddrs[i] == a) return i;
    return 0;
  endfunction

  task automatic waitSig(int which, output bit ok);
    int n = 0;
    logic s;
    s = (which == 0) ? snpReqValid : (which == 1) ? memReqValid : ioRspValid;
    while (!s && n < WAIT_MAX) begin
      @(negedge clk);
      n++;
      s = (which == 0) ? snpReqValid : (which == 1) ? memReqValid : ioRspValid;
    end
    ok = s;
    check(ok, "R8", $sformatf("timeout waiting on stage %0d", which), 0, 1);
  endtask

  // kind: 0 miss, 1 clean, 2 dirty
  task automatic runTxn(bit wr, int idx, logic [5:0] ofs, line_t data,
                        logic [63:0] be, int kind, line_t victim);
    logic [39:0] la = lineAddrs[idx];
    bit coh = cohRef(la);
    bit dirty = coh && (kind == 2);
    int s0 = snpCount, m0 = memCount;
    bit ok;
    line_t expRd = dirty ? victim : refMem[idx];
    @(negedge clk);
    ioValid = 1'b1; ioWrite = wr; ioAddr = la | {34'd0, ofs}; ioWdata = data; ioBe = be;
    @(negedge clk);
    ioValid = 1'b0;
    check(!ioReady, "R1", "ioReady after accept", ioReady, 0);
    if (coh) begin
      waitSig(0, ok);
      check(snpReqInv == wr, "R9", "snoop kind", snpReqInv, wr);
      check(snpReqAddr == la, "R9", "snoop line address", snpReqAddr, la);
      snpRspValid = 1'b1; snpRspDirty = dirty; snpRspData = victim;
      @(negedge clk);
      snpRspValid = 1'b0; snpRspDirty = 1'b0;
    end
    if (wr || !dirty) begin
      waitSig(1, ok);
      check(memReqWrite == wr, "R7", "memory op kind", memReqWrite, wr);
      check(memReqAddr == la, "R9", "memory line address", memReqAddr, la);
      if (wr && dirty) begin
        check(memReqBe == '1, "R4", "merged byte enables", memReqBe, {448'd0, 64'hFFFF_FFFF_FFFF_FFFF});
        check(memReqData == overlay(victim, data, be), "R4", "merged line",
              memReqData, overlay(victim, data, be));
      end else if (wr) begin
        check(memReqBe == be, "R5", "plain byte enables", memReqBe, be);
        check((memReqData & beMask(be)) == (data & beMask(be)), "R5", "plain data",
              memReqData & beMask(be), data & beMask(be));
      end
      if (memReqWrite) dutMem[idxOf(memReqAddr)] = overlay(dutMem[idxOf(memReqAddr)], memReqData, memReqBe);
      memRspData = dutMem[idxOf(memReqAddr)];
      memRspValid = 1'b1;
      @(negedge clk);
      memRspValid = 1'b0;
    end
    if (wr) refMem[idx] = dirty ? overlay(victim, data, be) : overlay(refMem[idx], data, be);
    waitSig(2, ok);
    if (!wr) check(ioRdata == expRd, dirty ? "R6" : "R7", "read data", ioRdata, expRd);
    @(negedge clk);
    check(!ioRspValid, "R8", "response pulse width", ioRspValid, 0);
    check(ioReady, "R1", "ready after response", ioReady, 1);
    check((snpCount - s0) == (coh ? 1 : 0), "R3", "snoop count", snpCount - s0, coh);
    check((memCount - m0) == ((wr || !dirty) ? 1 : 0), dirty ? "R6" : "R7", "memory request count",
          memCount - m0, (wr || !dirty));
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    nFails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks + 1, nFails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd7391));
    lineAddrs[0] = 40'h08_0000_0000; lineAddrs[1] = 40'h09_FFFF_FFC0;
    lineAddrs[2] = 40'h08_4000_1240; lineAddrs[3] = 40'h00_0C00_0000;
    lineAddrs[4] = 40'h00_0C5F_FFC0; lineAddrs[5] = 40'h07_FFFF_FFC0;
    lineAddrs[6] = 40'h0A_0000_0000; lineAddrs[7] = 40'h00_0C60_0000;
    for (int i = 0; i < NLINES; i++) begin
      dutMem[i] = randLine();
      refMem[i] = dutMem[i];
    end
    repeat (3) @(negedge clk);
    // R10: outputs during reset
    check(ioReady && !snpReqValid && !memReqValid && !ioRspValid, "R10", "reset state",
          {ioReady, snpReqValid, memReqValid, ioRspValid}, 4'b1000);
    rstN = 1'b1;
    @(negedge clk);
    check(ioReady && !snpReqValid && !memReqValid && !ioRspValid, "R10", "after reset",
          {ioReady, snpReqValid, memReqValid, ioRspValid}, 4'b1000);

    // Directed corners
    runTxn(1, 0, 6'd0,  randLine(), 64'h00FF_0F0F_F000_0001, 2, randLine()); // R4 merge
    runTxn(1, 1, 6'd17, randLine(), 64'hFFFF_0000_0000_FFFF, 1, randLine()); // R5 clean, top of window
    runTxn(1, 3, 6'd63, randLine(), 64'h0, 2, randLine());                   // R4 no enables
    runTxn(0, 4, 6'd5,  '0, '0, 2, randLine());                              // R6 dirty read scratch
    runTxn(0, 2, 6'd0,  '0, '0, 0, randLine());                              // R7 miss read
    runTxn(1, 5, 6'd0,  randLine(), 64'hFFFF_FFFF_FFFF_FFFF, 2, randLine()); // R3 below window
    runTxn(0, 6, 6'd9,  '0, '0, 2, randLine());                              // R3 above window
    runTxn(1, 7, 6'd1,  randLine(), 64'h8000_0000_0000_0001, 2, randLine()); // R3 past scratch

    // Random mix
    for (int t = 0; t < 300; t++) begin
      runTxn($urandom_range(0, 1), $urandom_range(0, NLINES-1), 6'($urandom()),
             randLine(), {$urandom(), $urandom()}, $urandom_range(0, 2), randLine());
    end

    // R4 R5: final memory contents against the reference
    for (int i = 0; i < NLINES; i++)
      check(dutMem[i] == refMem[i], "R5", $sformatf("final line %0d", i), dutMem[i], refMem[i]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule